// File: doc/BRIEF.md
# Table-Encoded Bus Clock-Enable Divider

This block turns a parent tick enable into a slower tick enable. Both run in one system clock domain, and it is meant for a peripheral bus that runs at a fraction of its parent rate. A two-bit ratio code sits in a small control register with a single write strobe and a read port. The code does not select a ratio by a plain power-of-two rule. A fixed lookup table maps codes 0 and 1 both to divide-by-2, code 2 to divide-by-4 and code 3 to divide-by-8.

The counter advances only on cycles that carry a parent tick, so the output spacing is always measured in parent ticks, however sparse those ticks are. A new code does not cut into the period in progress. The ratio in force is reloaded only at an output pulse. Every output period therefore equals either the old ratio or the new one, and no short or stretched period appears during a change.

Top module: `tkdiv_top`

## Requirements
- R1: A synchronous active-high reset leaves the stored code at 0, so the ratio is 2 and the read port shows 0. It also clears the count, so the first output pulse arrives on the second parent tick after reset.
- R2: A cycle with `wr_en` high stores `wr_data[1:0]` as the code and ignores the other write bits. From the next cycle on, `rd_data[1:0]` holds the stored code and every higher bit of `rd_data` reads 0.
- R3: With code 0 stored, `div_tick` pulses once every 2 parent ticks.
- R4: With code 1 stored, `div_tick` also pulses once every 2 parent ticks, giving the same spacing as code 0.
- R5: Code 2 gives one pulse every 4 parent ticks, and code 3 gives one pulse every 8 parent ticks.
- R6: A new code is adopted only at the first output pulse after it is stored. The period in progress finishes at the old ratio, and the periods after it use the new ratio.
- R7: `div_tick` is high only in a cycle where `par_tick` is high, and for one cycle per period. Cycles without a parent tick neither advance the count nor produce a pulse, so spacing in parent ticks does not depend on how far apart the parent ticks are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_tick | input | 1 | Parent tick enable, one cycle per parent period |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | DATA_W | Write data; bits 1:0 carry the ratio code |
| rd_data | output | DATA_W | Stored code in bits 1:0, zero above |
| div_tick | output | 1 | Divided tick enable |

## Verification
The bench builds the block with its default 32-bit register width and the fixed two-bit code. That reaches the whole lookup table, including the two codes that share divide-by-2, and the widest count of 8. Parent ticks are driven both back to back and with idle cycles between them, which shows that the spacing is counted in parent ticks. Changes of code are written at a known offset inside a period, in both directions, so that the old period can be seen finishing before the new ratio starts.

// File: rtl/tkdiv_pkg.sv
package tkdiv_pkg;

    // Width of the ratio code field in the control register
    localparam int CODE_W    = 2;
    localparam int NUM_CODES = 1 << CODE_W;

    // Power-of-two exponent selected by a code; the two lowest codes share one step
    function automatic int unsigned code_shift(input logic [CODE_W-1:0] code);
        return (code == '0) ? 32'd1 : 32'(code);
    endfunction

    function automatic int unsigned ratio_of(input logic [CODE_W-1:0] code);
        return 32'd1 << code_shift(code);
    endfunction

    function automatic int unsigned table_max();
        int unsigned m;
        m = 0;
        for (int c = 0; c < NUM_CODES; c++) begin
            if (ratio_of(CODE_W'(c)) > m) m = ratio_of(CODE_W'(c));
        end
        return m;
    endfunction

    localparam int unsigned MAX_RATIO = table_max();
    localparam int          CNT_W     = $clog2(MAX_RATIO);

    typedef logic [CNT_W-1:0]  term_t;
    typedef logic [CODE_W-1:0] code_t;

    // Terminal count (ratio minus one) after reset, from code 0
    localparam term_t RESET_TERM = term_t'(ratio_of('0) - 1);

    typedef struct packed {
        term_t cnt;
        term_t term;
    } div_state_t;

endpackage

// File: rtl/tkdiv_ctrl_reg.sv
module tkdiv_ctrl_reg
    import tkdiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output code_t             code_o,
    output logic [DATA_W-1:0] rd_data
);

    code_t code_q;
    logic  unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:CODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (wr_en) begin
            code_q <= wr_data[CODE_W-1:0];
        end
    end

    always_comb begin
        rd_data               = '0;
        rd_data[CODE_W-1:0]   = code_q;
    end

    assign code_o = code_q;

    // R2: a write lands in the readable field one cycle later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[CODE_W-1:0] == $past(wr_data[CODE_W-1:0])));

    // R2: without a write the stored code holds
    a_r2_code_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/tkdiv_ratio_lut.sv
module tkdiv_ratio_lut
    import tkdiv_pkg::*;
(
    input  code_t code_i,
    output term_t term_o
);

    term_t term_tab [NUM_CODES];

    // One table entry per code, computed from the shared exponent rule
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
        localparam int unsigned RATIO = ratio_of(CODE_W'(g));
        assign term_tab[g] = term_t'(RATIO - 1);
    end

    assign term_o = term_tab[code_i];

endmodule

// File: rtl/tkdiv_tick_counter.sv
module tkdiv_tick_counter
    import tkdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  par_tick,
    input  term_t next_term,
    output logic  div_tick
);

    div_state_t st_q;
    div_state_t st_d;
    logic       wrap;

    assign wrap = par_tick && (st_q.cnt == st_q.term);

    always_comb begin
        st_d = st_q;
        if (par_tick) begin
            if (wrap) begin
                st_d.cnt  = '0;
                st_d.term = next_term;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.term <= RESET_TERM;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_tick = wrap;

    // R3: the count never passes the terminal value in force
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= st_q.term);

    // R5: the ratio in force is always a table ratio (2, 4 or 8)
    a_r5_term_in_table: assert property (@(posedge clk) disable iff (rst)
        ($countones({1'b0, st_q.term} + 1'b1) == 1) && (st_q.term != '0));

    // R6: the ratio in force changes only right after an output pulse
    a_r6_term_moves_at_pulse: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.term) |-> $past(div_tick));

    // R7: cycles without a parent tick leave the state untouched
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !par_tick |=> ($stable(st_q.cnt) && $stable(st_q.term)));

endmodule

// File: rtl/tkdiv_top.sv
module tkdiv_top
    import tkdiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              par_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              div_tick
);

    code_t code_w;
    term_t term_w;

    tkdiv_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .code_o  (code_w),
        .rd_data (rd_data)
    );

    tkdiv_ratio_lut u_lut (
        .code_i (code_w),
        .term_o (term_w)
    );

    tkdiv_tick_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .par_tick  (par_tick),
        .next_term (term_w),
        .div_tick  (div_tick)
    );

    // R7: an output pulse only ever rides on a parent tick
    a_r7_pulse_on_parent: assert property (@(posedge clk) disable iff (rst)
        div_tick |-> par_tick);

endmodule

// File: tb/tkdiv_top_tb_top.sv
module tkdiv_top_tb_top;

    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              par_tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              div_tick;

    int checks   = 0;
    int failures = 0;
    int since    = 0;
    int orphan   = 0;
    int gaps[$];
    int gap_c0   = 0;
    int gap_c1   = 0;

    always #4 clk = ~clk;

    tkdiv_top #(.DATA_W(DATA_W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .par_tick (par_tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .div_tick (div_tick)
    );

    // Monitor: spacing of output pulses, counted in parent ticks
    always @(negedge clk) begin
        if (!rst) begin
            if (par_tick) since = since + 1;
            if (div_tick) begin
                gaps.push_back(since);
                since = 0;
            end
            if (div_tick && !par_tick) orphan = orphan + 1;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit t);
        @(posedge clk); #1;
        par_tick = t;
    endtask

    task automatic run_ticks(input int n, input int stride);
        for (int i = 0; i < n; i++) begin
            step(1'b1);
            for (int k = 1; k < stride; k++) step(1'b0);
        end
        step(1'b0);
    endtask

    task automatic write_reg(input logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        par_tick = 1'b0;
        wr_en    = 1'b1;
        wr_data  = d;
        @(posedge clk); #1;
        wr_en    = 1'b0;
    endtask

    // Advance parent ticks until a pulse, then start measuring from that boundary
    task automatic sync_to_pulse();
        gaps.delete();
        for (int i = 0; i < 64 && gaps.size() == 0; i++) begin
            step(1'b1);
            @(negedge clk); #1;
        end
        step(1'b0);
        gaps.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_eq("R1 read after reset", int'(rd_data), 0);
        check_eq("R1 no pulse after reset", int'(div_tick), 0);
        gaps.delete();
        since = 0;
        run_ticks(6, 1);
        check_eq("R1 pulse count after 6 ticks", gaps.size(), 3);
        if (gaps.size() > 0) check_eq("R1 first gap", gaps[0], 2);
    endtask

    task automatic t_register();
        write_reg(32'hFFFF_FFFE);
        @(negedge clk);
        check_eq("R2 upper bits dropped", int'(rd_data), 2);
        write_reg(32'h0000_0005);
        @(negedge clk);
        check_eq("R2 code 1 read", int'(rd_data), 1);
        write_reg(32'h8000_0003);
        @(negedge clk);
        check_eq("R2 code 3 read", int'(rd_data), 3);
        write_reg(32'h0);
        @(negedge clk);
        check_eq("R2 code 0 read", int'(rd_data), 0);
    endtask

    task automatic t_steady(input string req, input int code, input int ratio,
                            input int stride, output int gap_seen);
        write_reg(DATA_W'(code));
        sync_to_pulse();
        run_ticks(3 * ratio, stride);
        check_eq({req, " pulse count"}, gaps.size(), 3);
        gap_seen = (gaps.size() > 0) ? gaps[0] : -1;
        for (int i = 0; i < gaps.size(); i++) check_eq({req, " gap"}, gaps[i], ratio);
    endtask

    task automatic t_ratios();
        int g;
        t_steady("R3 code0", 0, 2, 1, gap_c0);
        t_steady("R4 code1", 1, 2, 1, gap_c1);
        check_eq("R4 code1 spacing equals code0", gap_c1, gap_c0);
        t_steady("R5 code2", 2, 4, 1, g);
        t_steady("R5 code3", 3, 8, 1, g);
        t_steady("R7 sparse code2", 2, 4, 3, g);
        t_steady("R7 sparse code1", 1, 2, 2, g);
    endtask

    task automatic t_change();
        write_reg(32'd3);
        sync_to_pulse();
        run_ticks(3, 1);
        write_reg(32'd2);
        run_ticks(13, 1);
        check_eq("R6 down pulse count", gaps.size(), 3);
        if (gaps.size() > 1) begin
            check_eq("R6 old period finishes", gaps[0], 8);
            check_eq("R6 new period applied", gaps[1], 4);
        end
        write_reg(32'd0);
        sync_to_pulse();
        run_ticks(1, 1);
        write_reg(32'd3);
        run_ticks(9, 1);
        check_eq("R6 up pulse count", gaps.size(), 2);
        if (gaps.size() > 1) begin
            check_eq("R6 short period finishes", gaps[0], 2);
            check_eq("R6 long period applied", gaps[1], 8);
        end
    endtask

    task automatic t_idle();
        gaps.delete();
        for (int i = 0; i < 40; i++) step(1'b0);
        check_eq("R7 no pulse while idle", gaps.size(), 0);
        check_eq("R7 pulse never without parent", orphan, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_register();
        t_ratios();
        t_change();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule